// File: doc/BRIEF.md
# CAN Transceiver Mode and Protection Controller

This block is the digital control core of a high-speed CAN line transceiver. A host selects between a full-power operating state and a low-power listening state through a single mode-select pin. The controller turns that request into enables for the bus driver, the main differential receiver and the low-power wake receiver. It also picks the bus common-mode bias and decides where the receive-data pin gets its value and whether that pin floats.

Three conditions take priority over the host request. An undervoltage on either the core supply or the I/O supply forces the low-power state, with the bus biased toward ground. An undervoltage on the I/O supply also floats the receive pin. An over-temperature flag or a disable from the companion dominant-timeout block turns off only the driver and leaves the bus at its recessive mid-supply bias. When both supplies become valid again, the controller waits a programmable number of clock cycles before it honours the mode pin.

The controller has four states. FORCED_SB is entered on reset and whenever a supply is low. SETTLE runs the recovery delay. NORMAL allows transmit. STANDBY is the low-power state that the host requests. The transitions are:
- FORCED_SB to SETTLE once both supplies are good.
- SETTLE to NORMAL or STANDBY when the delay expires, according to the mode pin.
- NORMAL to STANDBY when the mode pin goes high, and back again when it goes low.
- Any state to FORCED_SB on undervoltage.

All outputs are registered. They are computed from the next state and the current inputs, so each output changes on the clock edge that samples its cause.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While reset is asserted, the outputs are: driver off, main receiver off, wake receiver off, bias at ground (`bias_mid_o`=0), receive data sourced from the wake path (`rxd_from_wake_o`=1), and the receive pin floating (`rxd_hiz_o`=1).
- R2: In NORMAL with both fault flags low, the outputs are: driver on, main receiver on, wake receiver off, mid-supply bias (`bias_mid_o`=1), and receive data from the main receiver (`rxd_from_wake_o`=0). This holds on the first edge after `stb_i` goes low in STANDBY.
- R3: With `stb_i` high in a settled state, the controller is in STANDBY on the next edge. There, the driver and main receiver are off, the wake receiver is on, the bias is ground, and receive data comes from the wake path.
- R4: An undervoltage on either supply turns the driver off and moves the bias to ground on the edge that samples it, whatever the level of `stb_i`.
- R5: During an I/O-supply undervoltage the receive pin floats and the wake receiver is off. During a core-only undervoltage the receive pin is driven from the wake path and the wake receiver stays on.
- R6: After the last edge that samples an undervoltage, the first edge that sees both supplies good enters SETTLE. The controller then stays in SETTLE for exactly `SETTLE_CYCLES` edges and reaches NORMAL on edge `SETTLE_CYCLES`+1. A new undervoltage during SETTLE restarts the whole delay.
- R7: `ot_i` high turns off only the driver on the next edge. The main receiver stays on and the bias stays at mid-supply, and the driver returns once the flag clears in NORMAL.
- R8: `tmo_dis_i` high turns off only the driver, in the same way as R7.
- R9: The driver is never enabled unless the main receiver is enabled and the bias is at mid-supply.
- R10: When the delay expires with `stb_i` high, the controller enters STANDBY, not NORMAL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stb_i | input | 1 | Mode request: 0 normal, 1 standby |
| uv_core_i | input | 1 | Core supply undervoltage flag |
| uv_io_i | input | 1 | I/O supply undervoltage flag |
| ot_i | input | 1 | Over-temperature flag |
| tmo_dis_i | input | 1 | Driver disable from the dominant-timeout block |
| drv_en_o | output | 1 | Bus driver enable |
| rx_main_en_o | output | 1 | Main differential receiver enable |
| rx_wake_en_o | output | 1 | Low-power wake receiver and monitor enable |
| bias_mid_o | output | 1 | Bus bias: 1 mid-supply, 0 ground |
| rxd_from_wake_o | output | 1 | Receive data source: 0 main receiver, 1 wake filter |
| rxd_hiz_o | output | 1 | Receive pin high impedance |

## Verification
The bench measures the recovery delay edge by edge, both from reset and after an undervoltage pulse inside SETTLE. An off-by-one counter would enable the driver one edge early or late, and a timer that is not restarted would finish the delay too soon. The bench holds `stb_i` low during undervoltage and confirms that the driver stays off, which catches a design that lets the host request override the supply fault. It tells the two supply faults apart by their receive-pin behaviour: a design that floats the pin on a core-only fault, or keeps the wake receiver on with the I/O supply gone, fails there. It also applies thermal and timeout flags in NORMAL. A design that drops the bias or the receiver along with the driver, or treats these flags as forcing standby, is caught.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;

    typedef enum logic [1:0] {
        ST_FORCED_SB = 2'd0,
        ST_SETTLE    = 2'd1,
        ST_NORMAL    = 2'd2,
        ST_STANDBY   = 2'd3
    } ctl_state_t;

    typedef struct packed {
        logic drv_en;
        logic rx_main_en;
        logic rx_wake_en;
        logic bias_mid;
        logic rxd_from_wake;
        logic rxd_hiz;
    } ctl_out_t;

    localparam ctl_out_t OUT_RESET = '{
        drv_en:        1'b0,
        rx_main_en:    1'b0,
        rx_wake_en:    1'b0,
        bias_mid:      1'b0,
        rxd_from_wake: 1'b1,
        rxd_hiz:       1'b1
    };

endpackage

// File: rtl/xcvr_settle_timer.sv
module xcvr_settle_timer #(
    parameter int LIMIT = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Counter only advances while the FSM sits in SETTLE; leaving clears it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/xcvr_mode_fsm.sv
module xcvr_mode_fsm
    import xcvr_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb_i,
    input  logic       uv_any_i,
    input  logic       settle_done_i,
    output ctl_state_t state_o,
    output ctl_state_t next_o
);
    ctl_state_t state_q;
    ctl_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FORCED_SB;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FORCED_SB: begin
                if (!uv_any_i) state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (uv_any_i)           state_d = ST_FORCED_SB;
                else if (settle_done_i) state_d = stb_i ? ST_STANDBY : ST_NORMAL;
            end
            ST_NORMAL: begin
                if (uv_any_i)   state_d = ST_FORCED_SB;
                else if (stb_i) state_d = ST_STANDBY;
            end
            ST_STANDBY: begin
                if (uv_any_i)    state_d = ST_FORCED_SB;
                else if (!stb_i) state_d = ST_NORMAL;
            end
            default: state_d = ST_FORCED_SB;
        endcase
    end

    assign state_o = state_q;
    assign next_o  = state_d;

endmodule

// File: rtl/xcvr_out_decode.sv
module xcvr_out_decode
    import xcvr_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ctl_state_t next_i,
    input  logic       uv_io_i,
    input  logic       ot_i,
    input  logic       tmo_dis_i,
    output ctl_out_t   out_o
);
    ctl_out_t out_d;
    ctl_out_t out_q;

    always_comb begin
        out_d = OUT_RESET;
        unique case (next_i)
            ST_FORCED_SB: begin
                out_d.rx_wake_en    = !uv_io_i;
                out_d.rxd_from_wake = 1'b1;
                out_d.rxd_hiz       = uv_io_i;
            end
            ST_SETTLE, ST_STANDBY: begin
                out_d.rx_wake_en    = 1'b1;
                out_d.rxd_from_wake = 1'b1;
                out_d.rxd_hiz       = 1'b0;
            end
            ST_NORMAL: begin
                out_d.drv_en        = !ot_i && !tmo_dis_i;
                out_d.rx_main_en    = 1'b1;
                out_d.rx_wake_en    = 1'b0;
                out_d.bias_mid      = 1'b1;
                out_d.rxd_from_wake = 1'b0;
                out_d.rxd_hiz       = 1'b0;
            end
            default: out_d = OUT_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= OUT_RESET;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_o = out_q;

endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
    import xcvr_mode_pkg::*;
#(
    parameter int SETTLE_CYCLES = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic uv_core_i,
    input  logic uv_io_i,
    input  logic ot_i,
    input  logic tmo_dis_i,
    output logic drv_en_o,
    output logic rx_main_en_o,
    output logic rx_wake_en_o,
    output logic bias_mid_o,
    output logic rxd_from_wake_o,
    output logic rxd_hiz_o
);
    ctl_state_t state_w;
    ctl_state_t next_w;
    ctl_out_t   outs_w;
    logic       uv_any_w;
    logic       settle_done_w;
    logic       settle_run_w;

    assign uv_any_w     = uv_core_i || uv_io_i;
    assign settle_run_w = (state_w == ST_SETTLE);

    xcvr_settle_timer #(.LIMIT(SETTLE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (settle_run_w),
        .done_o (settle_done_w)
    );

    xcvr_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .stb_i         (stb_i),
        .uv_any_i      (uv_any_w),
        .settle_done_i (settle_done_w),
        .state_o       (state_w),
        .next_o        (next_w)
    );

    xcvr_out_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .next_i    (next_w),
        .uv_io_i   (uv_io_i),
        .ot_i      (ot_i),
        .tmo_dis_i (tmo_dis_i),
        .out_o     (outs_w)
    );

    assign drv_en_o        = outs_w.drv_en;
    assign rx_main_en_o    = outs_w.rx_main_en;
    assign rx_wake_en_o    = outs_w.rx_wake_en;
    assign bias_mid_o      = outs_w.bias_mid;
    assign rxd_from_wake_o = outs_w.rxd_from_wake;
    assign rxd_hiz_o       = outs_w.rxd_hiz;

endmodule

// File: rtl/xcvr_mode_ctrl_chk.sv
module xcvr_mode_ctrl_chk #(
    parameter int SETTLE_CYCLES = 30000
) (
    input logic clk,
    input logic rst_n,
    input logic stb_i,
    input logic uv_core_i,
    input logic uv_io_i,
    input logic ot_i,
    input logic tmo_dis_i,
    input logic drv_en_o,
    input logic rx_main_en_o,
    input logic rx_wake_en_o,
    input logic bias_mid_o,
    input logic rxd_from_wake_o,
    input logic rxd_hiz_o
);
    localparam int GW = $clog2(SETTLE_CYCLES + 2);
    localparam logic [GW-1:0] GMAX = GW'(SETTLE_CYCLES + 1);

    // Independent count of consecutive edges with both supplies good.
    logic [GW-1:0] good_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_cnt <= '0;
        end else if (uv_core_i || uv_io_i) begin
            good_cnt <= '0;
        end else if (good_cnt != GMAX) begin
            good_cnt <= good_cnt + 1'b1;
        end
    end

    assert_settle_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bias_mid_o |-> (good_cnt >= GW'(SETTLE_CYCLES)));

    assert_uv_forces_sb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_core_i || uv_io_i) |=> (!drv_en_o && !bias_mid_o));

    assert_io_uv_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        uv_io_i |=> (rxd_hiz_o && !rx_wake_en_o));

    assert_core_uv_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_core_i && !uv_io_i) |=> (!rxd_hiz_o && rx_wake_en_o));

    assert_thermal_drv_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ot_i |=> !drv_en_o);

    assert_tmo_drv_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_dis_i |=> !drv_en_o);

    assert_drv_needs_normal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_o |-> (rx_main_en_o && bias_mid_o));

    assert_main_rx_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_main_en_o |-> (!rxd_from_wake_o && !rx_wake_en_o));

    assert_wake_rx_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wake_en_o |-> (rxd_from_wake_o && !rx_main_en_o));

    assert_stb_leaves_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && bias_mid_o) |=> !bias_mid_o);

endmodule

bind xcvr_mode_ctrl xcvr_mode_ctrl_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .stb_i           (stb_i),
    .uv_core_i       (uv_core_i),
    .uv_io_i         (uv_io_i),
    .ot_i            (ot_i),
    .tmo_dis_i       (tmo_dis_i),
    .drv_en_o        (drv_en_o),
    .rx_main_en_o    (rx_main_en_o),
    .rx_wake_en_o    (rx_wake_en_o),
    .bias_mid_o      (bias_mid_o),
    .rxd_from_wake_o (rxd_from_wake_o),
    .rxd_hiz_o       (rxd_hiz_o)
);

// File: tb/xcvr_mode_ctrl_test.sv
`timescale 1ns/1ps
module xcvr_mode_ctrl_test;
    localparam int N = 8;

    // Output pattern order: {drv, main, wake, bias_mid, from_wake, hiz}
    localparam logic [5:0] P_RESET  = 6'b000011;
    localparam logic [5:0] P_NORMAL = 6'b110100;
    localparam logic [5:0] P_NODRV  = 6'b010100;
    localparam logic [5:0] P_SB     = 6'b001010;
    localparam logic [5:0] P_IOUV   = 6'b000011;

    // Vector: {stb, ot, tmo, expected[5:0]}
    localparam logic [8:0] VEC [9] = '{
        {3'b000, P_NORMAL},
        {3'b010, P_NODRV},
        {3'b001, P_NODRV},
        {3'b011, P_NODRV},
        {3'b100, P_SB},
        {3'b110, P_SB},
        {3'b000, P_NORMAL},
        {3'b101, P_SB},
        {3'b000, P_NORMAL}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 1'b0, uv_core = 1'b0, uv_io = 1'b0, ot = 1'b0, tmo = 1'b0;
    logic drv, mrx, wrx, bmid, fwake, hiz;
    int   errors = 0;
    int   checks = 0;

    always #5 clk = ~clk;

    xcvr_mode_ctrl #(.SETTLE_CYCLES(N)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .stb_i           (stb),
        .uv_core_i       (uv_core),
        .uv_io_i         (uv_io),
        .ot_i            (ot),
        .tmo_dis_i       (tmo),
        .drv_en_o        (drv),
        .rx_main_en_o    (mrx),
        .rx_wake_en_o    (wrx),
        .bias_mid_o      (bmid),
        .rxd_from_wake_o (fwake),
        .rxd_hiz_o       (hiz)
    );

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] got;
        got = {drv, mrx, wrx, bmid, fwake, hiz};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset outputs", P_RESET);
        rst_n = 1'b1;

        // R6: settle from reset, exact edge count
        edges(1);
        check("R6 settle entered", P_SB);
        edges(N - 1);
        check("R6 still settling at edge N", P_SB);
        edges(1);
        check("R6 normal at edge N+1", P_NORMAL);

        // Vector table: R2, R3, R7, R8
        for (int i = 0; i < 9; i++) begin
            {stb, ot, tmo} = VEC[i][8:6];
            edges(1);
            check($sformatf("R2/R3/R7/R8 vector %0d", i), VEC[i][5:0]);
        end
        ot = 1'b0; tmo = 1'b0; stb = 1'b0;

        // R4, R5: core undervoltage with stb low
        uv_core = 1'b1;
        edges(1);
        check("R4 core uv forces standby, R5 rxd driven", P_SB);
        edges(3);
        check("R4 stb low ignored under uv", P_SB);

        // R6: restart of the delay
        uv_core = 1'b0;
        edges(4);
        check("R6 partial settle", P_SB);
        uv_core = 1'b1;
        edges(1);
        check("R4 uv during settle", P_SB);
        uv_core = 1'b0;
        edges(N);
        check("R6 restarted delay not expired", P_SB);
        edges(1);
        check("R6 restarted delay expired", P_NORMAL);

        // R5: I/O undervoltage
        uv_io = 1'b1;
        edges(1);
        check("R5 io uv floats rxd", P_IOUV);
        uv_io = 1'b0;
        uv_core = 1'b1;
        edges(1);
        check("R5 core-only uv drives rxd", P_SB);

        // R10: delay ends with stb high
        uv_core = 1'b0;
        stb = 1'b1;
        edges(N + 1);
        check("R10 settle ends in standby", P_SB);
        stb = 1'b0;
        edges(1);
        check("R2 standby to normal", P_NORMAL);

        // R7: thermal keeps bias and receiver, driver back after clear
        ot = 1'b1;
        edges(2);
        check("R7 thermal only driver off", P_NODRV);
        ot = 1'b0;
        edges(1);
        check("R7 driver back after clear", P_NORMAL);

        // R1: reset mid-operation
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset reapplied", P_RESET);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule